// File: doc/BRIEF.md
# Virtually Indexed, Virtually Tagged Data Cache

A direct-mapped data cache that selects the set and compares the tag using the virtual address. A hit never consults address translation. Every line carries extra fields: the process identifier that filled it, the two permission bits that the translation unit returned for it, and the physical line address it was fetched from. Because of the identifier, lines of several processes can stay resident across context switches, and a hit requires the current identifier to match.

On a miss the cache asks an external translation port for the physical line address and permission bits. It then reads the words of the line from a simple memory read port, one request per word. While the words arrive, a scanner visits every line, one per cycle. Any other resident line that holds the same physical line (an alias) is invalidated. The new line is installed only after both the fetch and the scan have finished, and the access is then replayed as a hit. Stores are write-allocate and update only the cached copy. A one-cycle flush input clears every valid bit.

Top module: `vivt_cache`

## Requirements
- R1: An access is accepted when `cpu_ready` is high. Address bits [7:4] select one of 16 lines and bits [31:8] form the tag. The access hits when that line is valid, its tag matches, and its stored identifier equals `cpu_pid`. A hit raises `cpu_done` for one cycle, two clock edges after acceptance, and makes no translation request.
- R2: A load returns the word selected by address bits [3:2] on `cpu_rdata`. A permitted store replaces that word, and later loads of the line return the stored value.
- R3: A miss makes exactly one translation request, carrying the access address and identifier. It then reads the 4 words of the line in order 0..3, at byte addresses `{xl_pline, k, 2'b00}`, holding each request and address until `mem_valid`.
- R4: A filled line keeps the permission bits from the translation response: bit 1 allows stores and bit 0 allows loads. An access that lacks its permission sets `cpu_fault` together with `cpu_done`, and the line data is left unchanged.
- R5: A line whose stored identifier differs from `cpu_pid` does not hit. Lines filled under one identifier still hit after accesses under another identifier have been made to other sets.
- R6: Before a fill is installed, every other valid line whose stored physical line address equals that of the fill is invalidated. The fill waits for a scan of all 16 lines, so a miss takes at least 20 edges from acceptance to `cpu_done`.
- R7: A cycle with `flush` high clears every valid bit, so the next access to any previously resident line misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Invalidate all lines |
| cpu_req | input | 1 | Access request, sampled while ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_va | input | 32 | Virtual byte address |
| cpu_pid | input | 8 | Current process identifier |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Idle, able to accept |
| cpu_done | output | 1 | Access complete (one cycle) |
| cpu_fault | output | 1 | Permission fault, with done |
| cpu_rdata | output | 32 | Load data, valid with done |
| xl_req | output | 1 | Translation request |
| xl_va | output | 32 | Address to translate |
| xl_pid | output | 8 | Identifier to translate under |
| xl_valid | input | 1 | Translation response strobe |
| xl_pline | input | 28 | Physical line address |
| xl_perm | input | 2 | Permissions: bit 1 store, bit 0 load |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 32 | Physical byte address of word |
| mem_valid | input | 1 | Read data strobe |
| mem_rdata | input | 32 | Read data |

## Verification
The assertions assume that `xl_valid` pulses only while `xl_req` is high and `mem_valid` only while `mem_req` is high, each for a single cycle per request, and that `flush` and `cpu_req` are low out of reset. The bench responders answer only an open request that they have not yet answered, after a random delay of zero to two cycles. The bench raises `flush` only while the cache is idle and presents a request for exactly one cycle while `cpu_ready` is high. Random addresses are drawn from a small pool with regions of differing permissions and a region where all addresses share one physical line, so hits, identifier mismatches, aliases and faults all recur.

// File: rtl/vivt_cache.sv
module vivt_cache #(
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int PID_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         cpu_req,
  input  logic                         cpu_we,
  input  logic [VA_W-1:0]              cpu_va,
  input  logic [PID_W-1:0]             cpu_pid,
  input  logic [DATA_W-1:0]            cpu_wdata,
  output logic                         cpu_ready,
  output logic                         cpu_done,
  output logic                         cpu_fault,
  output logic [DATA_W-1:0]            cpu_rdata,
  output logic                         xl_req,
  output logic [VA_W-1:0]              xl_va,
  output logic [PID_W-1:0]             xl_pid,
  input  logic                         xl_valid,
  input  logic [PA_W-$clog2(WORDS)-3:0] xl_pline,
  input  logic [1:0]                   xl_perm,
  output logic                         mem_req,
  output logic [PA_W-1:0]              mem_addr,
  input  logic                         mem_valid,
  input  logic [DATA_W-1:0]            mem_rdata
);
  localparam int WS_W  = $clog2(WORDS);
  localparam int OFF_W = WS_W + 2;
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = VA_W - IDX_W - OFF_W;
  localparam int PL_W  = PA_W - OFF_W;

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_XL, S_FILL} st_t;
  st_t state;

  logic [LINES-1:0]  vld;
  logic [TAG_W-1:0]  tag_a  [LINES];
  logic [PID_W-1:0]  pid_a  [LINES];
  logic [PL_W-1:0]   pl_a   [LINES];
  logic [1:0]        perm_a [LINES];
  logic [DATA_W-1:0] dat    [LINES][WORDS];

  logic              r_we;
  logic [VA_W-1:0]   r_va;
  logic [PID_W-1:0]  r_pid;
  logic [DATA_W-1:0] r_wd;
  logic [PL_W-1:0]   f_pl;
  logic [1:0]        f_perm;
  logic [WS_W-1:0]   wcnt;
  logic [IDX_W-1:0]  scn;
  logic              wdone, sdone;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  vtag;
  logic [WS_W-1:0]   wsel;
  logic              hit, perm_ok;
  logic              unused_lsb;

  assign idx        = r_va[OFF_W +: IDX_W];
  assign vtag       = r_va[VA_W-1 -: TAG_W];
  assign wsel       = r_va[2 +: WS_W];
  assign hit        = vld[idx] && (tag_a[idx] == vtag) && (pid_a[idx] == r_pid);
  assign perm_ok    = r_we ? perm_a[idx][1] : perm_a[idx][0];
  assign unused_lsb = ^r_va[1:0];

  assign cpu_ready = (state == S_IDLE);
  assign xl_req    = (state == S_XL);
  assign xl_va     = r_va;
  assign xl_pid    = r_pid;
  assign mem_req   = (state == S_FILL) && !wdone;
  assign mem_addr  = {f_pl, wcnt, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      vld       <= '0;
      cpu_done  <= 1'b0;
      cpu_fault <= 1'b0;
      cpu_rdata <= '0;
      r_we      <= 1'b0;
      r_va      <= '0;
      r_pid     <= '0;
      r_wd      <= '0;
      f_pl      <= '0;
      f_perm    <= '0;
      wcnt      <= '0;
      scn       <= '0;
      wdone     <= 1'b0;
      sdone     <= 1'b0;
    end else begin
      cpu_done  <= 1'b0;
      cpu_fault <= 1'b0;
      case (state)
        S_IDLE: if (cpu_req) begin
          r_we  <= cpu_we;
          r_va  <= cpu_va;
          r_pid <= cpu_pid;
          r_wd  <= cpu_wdata;
          state <= S_LOOK;
        end
        S_LOOK: if (hit) begin
          cpu_done <= 1'b1;
          state    <= S_IDLE;
          if (!perm_ok) cpu_fault <= 1'b1;
          else if (r_we) dat[idx][wsel] <= r_wd;
          else cpu_rdata <= dat[idx][wsel];
        end else begin
          state <= S_XL;
        end
        S_XL: if (xl_valid) begin
          f_pl     <= xl_pline;
          f_perm   <= xl_perm;
          vld[idx] <= 1'b0;
          wcnt     <= '0;
          scn      <= '0;
          wdone    <= 1'b0;
          sdone    <= 1'b0;
          state    <= S_FILL;
        end
        S_FILL: begin
          if (!wdone && mem_valid) begin
            dat[idx][wcnt] <= mem_rdata;
            wcnt <= wcnt + 1'b1;
            if (wcnt == WS_W'(WORDS-1)) wdone <= 1'b1;
          end
          if (!sdone) begin
            if (scn != idx && vld[scn] && pl_a[scn] == f_pl) vld[scn] <= 1'b0;
            scn <= scn + 1'b1;
            if (scn == IDX_W'(LINES-1)) sdone <= 1'b1;
          end
          if (wdone && sdone) begin
            vld[idx]    <= 1'b1;
            tag_a[idx]  <= vtag;
            pid_a[idx]  <= r_pid;
            pl_a[idx]   <= f_pl;
            perm_a[idx] <= f_perm;
            state       <= S_LOOK;
          end
        end
        default: state <= S_IDLE;
      endcase
      if (flush) vld <= '0;
    end
  end
endmodule

module vivt_cache_chk #(
  parameter int LINES = 16,
  parameter int VA_W  = 32,
  parameter int PA_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             cpu_ready,
  input logic             cpu_done,
  input logic             cpu_fault,
  input logic             xl_req,
  input logic             xl_valid,
  input logic [VA_W-1:0]  xl_va,
  input logic             mem_req,
  input logic             mem_valid,
  input logic [PA_W-1:0]  mem_addr,
  input logic [LINES-1:0] vld
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) cpu_done |=> !cpu_done); // R1
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) cpu_done |-> cpu_ready); // R1
  AST_FAULT_DONE: assert property (@(posedge clk) disable iff (!rst_n) cpu_fault |-> cpu_done); // R4
  AST_XL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (xl_req && !xl_valid) |=> (xl_req && $stable(xl_va))); // R3
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr))); // R3
  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(xl_req && mem_req)); // R3
  AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) flush |=> (vld == '0)); // R7
endmodule

bind vivt_cache vivt_cache_chk #(.LINES(LINES), .VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .cpu_ready(cpu_ready), .cpu_done(cpu_done),
  .cpu_fault(cpu_fault), .xl_req(xl_req), .xl_valid(xl_valid), .xl_va(xl_va),
  .mem_req(mem_req), .mem_valid(mem_valid), .mem_addr(mem_addr), .vld(vld)
);

// File: tb/vivt_cache_tb.sv
module vivt_cache_tb;
  logic clk = 0, rst_n = 0, flush = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [31:0] cpu_va = 0, cpu_wdata = 0;
  logic [7:0] cpu_pid = 0;
  logic cpu_ready, cpu_done, cpu_fault;
  logic [31:0] cpu_rdata;
  logic xl_req, xl_valid = 0;
  logic [31:0] xl_va;
  logic [7:0] xl_pid;
  logic [27:0] xl_pline = 0;
  logic [1:0] xl_perm = 0;
  logic mem_req, mem_valid = 0;
  logic [31:0] mem_addr, mem_rdata = 0;

  int total = 0, bad = 0, xl_cnt = 0, cyc = 0;
  int xl_wait = 0, mem_wait = 0;

  always #2 clk = ~clk;

  vivt_cache u_dut (.*);

  function automatic logic [31:0] mw(input logic [31:0] a);
    return a * 32'h9E3779B1 + 32'h0123_4567;
  endfunction
  function automatic logic [27:0] xpl(input logic [31:0] va, input logic [7:0] pid);
    if (va[31:28] == 4'hA) return 28'h550_0000;
    return {va[31:24] ^ pid, va[23:4]};
  endfunction
  function automatic logic [1:0] xpm(input logic [31:0] va);
    if (va[31:28] == 4'hB) return 2'b01;
    if (va[31:28] == 4'hC) return 2'b10;
    return 2'b11;
  endfunction

  always @(posedge clk) begin
    xl_valid <= 1'b0;
    if (xl_req && !xl_valid) begin
      if (xl_wait == 0) begin
        xl_valid <= 1'b1;
        xl_pline <= xpl(xl_va, xl_pid);
        xl_perm  <= xpm(xl_va);
        xl_cnt   <= xl_cnt + 1;
        xl_wait  <= int'($urandom % 3);
      end else xl_wait <= xl_wait - 1;
    end
    mem_valid <= 1'b0;
    if (mem_req && !mem_valid) begin
      if (mem_wait == 0) begin
        mem_valid <= 1'b1;
        mem_rdata <= mw(mem_addr);
        mem_wait  <= int'($urandom % 3);
      end else mem_wait <= mem_wait - 1;
    end
  end

  logic        m_v   [16];
  logic [23:0] m_tag [16];
  logic [7:0]  m_pid [16];
  logic [27:0] m_pl  [16];
  logic [1:0]  m_pm  [16];
  logic [31:0] m_d   [16][4];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic model(input bit we, input logic [31:0] va, input logic [7:0] pid,
                       input logic [31:0] wd, output bit miss, output bit flt,
                       output logic [31:0] rd);
    int i = int'(va[7:4]);
    bit ok;
    miss = !(m_v[i] && m_tag[i] == va[31:8] && m_pid[i] == pid);
    if (miss) begin
      logic [27:0] pl = xpl(va, pid);
      for (int j = 0; j < 16; j++) if (j != i && m_v[j] && m_pl[j] == pl) m_v[j] = 0;
      for (int k = 0; k < 4; k++) m_d[i][k] = mw({pl, 2'(k), 2'b00});
      m_v[i] = 1; m_tag[i] = va[31:8]; m_pid[i] = pid; m_pl[i] = pl; m_pm[i] = xpm(va);
    end
    ok = we ? m_pm[i][1] : m_pm[i][0];
    flt = !ok;
    rd = m_d[i][va[3:2]];
    if (ok && we) m_d[i][va[3:2]] = wd;
  endtask

  task automatic acc(input bit we, input logic [31:0] va, input logic [7:0] pid,
                     input logic [31:0] wd, output logic [31:0] rd, output bit flt,
                     output int n, output int nxl);
    int x0;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_va = va; cpu_pid = pid; cpu_wdata = wd;
    x0 = xl_cnt;
    @(negedge clk);
    cpu_req = 0; n = 1;
    while (!cpu_done && n < 2000) begin @(negedge clk); n++; end
    rd = cpu_rdata; flt = cpu_fault; nxl = xl_cnt - x0;
  endtask

  task automatic run(input bit we, input logic [31:0] va, input logic [7:0] pid,
                     input logic [31:0] wd, input string rq, output bit miss, output int n);
    logic [31:0] rd, erd;
    bit flt, eflt;
    int nxl;
    model(we, va, pid, wd, miss, eflt, erd);
    acc(we, va, pid, wd, rd, flt, n, nxl);
    chk(flt == eflt, rq, "fault (R4)", 32'(flt), 32'(eflt));
    chk(nxl == int'(miss), rq, "translation count (R3)", 32'(nxl), 32'(miss));
    if (!we && !eflt) chk(rd == erd, rq, "load data (R2)", rd, erd);
    if (!miss) chk(n == 2, rq, "hit latency (R1)", 32'(n), 32'd2);
    else chk(n >= 20, rq, "miss scan latency (R6)", 32'(n), 32'd20);
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    for (int j = 0; j < 16; j++) m_v[j] = 0;
  endtask

  initial begin
    bit ms;
    int n;
    void'($urandom(32'd2024));
    for (int j = 0; j < 16; j++) m_v[j] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cpu_ready && !cpu_done && !xl_req && !mem_req, "R1", "reset idle",
        {28'h0, cpu_ready, cpu_done, xl_req, mem_req}, 32'h8);

    // R1 R2 R3: miss then hit, store then load
    run(0, 32'h1234_5678, 8'd1, 0, "R3", ms, n);
    chk(ms, "R3", "first access misses", 32'(ms), 1);
    run(0, 32'h1234_567C, 8'd1, 0, "R1", ms, n);
    chk(!ms, "R1", "same line hits", 32'(ms), 0);
    run(1, 32'h1234_5674, 8'd1, 32'hCAFE_F00D, "R2", ms, n);
    run(0, 32'h1234_5674, 8'd1, 0, "R2", ms, n);

    // R5: identifier tagging
    run(0, 32'h0000_7770, 8'd1, 0, "R5", ms, n);
    run(0, 32'h0000_7770, 8'd2, 0, "R5", ms, n);
    chk(ms, "R5", "other pid misses", 32'(ms), 1);
    run(0, 32'h0000_3330, 8'd1, 0, "R5", ms, n);
    run(0, 32'h0000_8880, 8'd2, 0, "R5", ms, n);
    run(0, 32'h0000_3330, 8'd1, 0, "R5", ms, n);
    chk(!ms, "R5", "line survives pid switch", 32'(ms), 0);

    // R6: alias in another set
    run(0, 32'hA000_0010, 8'd1, 0, "R6", ms, n);
    run(0, 32'hA000_0020, 8'd3, 0, "R6", ms, n);
    run(0, 32'hA000_0014, 8'd1, 0, "R6", ms, n);
    chk(ms, "R6", "alias invalidated", 32'(ms), 1);

    // R4: permissions
    run(1, 32'hB000_0050, 8'd1, 32'h1111_2222, "R4", ms, n);
    run(0, 32'hB000_0050, 8'd1, 0, "R4", ms, n);
    run(0, 32'hC000_0060, 8'd1, 0, "R4", ms, n);
    run(1, 32'hC000_0064, 8'd1, 32'h3333_4444, "R4", ms, n);

    // R7: flush
    run(0, 32'h1234_5678, 8'd1, 0, "R7", ms, n);
    do_flush();
    run(0, 32'h1234_5678, 8'd1, 0, "R7", ms, n);
    chk(ms, "R7", "miss after flush", 32'(ms), 1);

    for (int t = 0; t < 400; t++) begin
      logic [3:0] rg;
      logic [31:0] va;
      int r = int'($urandom % 100);
      case ($urandom % 5) 0: rg = 4'h0; 1: rg = 4'h1; 2: rg = 4'hA; 3: rg = 4'hB; default: rg = 4'hC; endcase
      va = {rg, 16'h0, 4'($urandom % 2), 4'($urandom), 2'($urandom), 2'b00};
      if (r < 3) do_flush();
      else run(r < 33, va, 8'(1 + $urandom % 2), $urandom, "R2", ms, n);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog R1: actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule